// File: doc/BRIEF.md
# Keyed Configuration Port

This block is a byte-wide configuration window that sits on an I/O bus at two consecutive addresses. It stays closed after reset; host software must write a fixed four-byte key to the lower of the two addresses before anything behind it is visible. The last byte of that key depends on which of two base addresses the instance is strapped to. This lets two instances share one bus without one instance's key opening the other.

Once open, the lower address selects a register by index and the upper address reads or writes that register. The register file holds a constant device identifier, a device-select register and a global serial-flash control byte. It also holds a 16-bit I/O base pair that exists only for the flash device number. The decoded flash-control fields and the base address leave the block as plain outputs for the flash segment logic and the SPI engine. Writing the exit value to the exit index closes the window again.

Top module: `cfg_unlock_port`

## Requirements
- R1: The window opens only after the byte sequence 0x87, 0x01, 0x55, K is written to the index address, where K is 0x55 for base address 0x002E and 0xAA for base address 0x004E; `cfg_open` is high from the cycle after the last key byte.
- R2: A key byte that does not match restarts the key search; a mismatching byte equal to 0x87 counts as the first key byte of a new attempt.
- R3: While open, writing 0x02 to the data address with index 0x02 selected closes the window, and `cfg_open` is low from the next cycle.
- R4: While closed, every read at either address returns 0xFF and data-address writes change no register.
- R5: The index register is at the base address and the data register at base+1; a read returns its byte on `rd_data` with `rd_valid` high exactly one cycle after `rd_en`.
- R6: Index 0x20 reads the identifier high byte 0x87 and index 0x21 the low byte 0x16; both are read-only.
- R7: Index 0x07 is a read/write device select; indices 0x64 and 0x65 are writable and readable only while the device select holds 7, otherwise they read 0x00 and writes to them are dropped.
- R8: Index 0x24 is a read/write flash-control byte; bit 0 drives `flash_suspend`, bits 3..1 drive `flash_seg_en[2:0]`, bit 4 drives `flash_host_wr`, bit 5 drives `flash_pin_sel`.
- R9: After reset the window is closed, the device select is 0, the flash-control byte is 0 and the base address is 0x0000.
- R10: `flash_base` equals index 0x64 as high byte concatenated with index 0x65 as low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | I/O address of the current access |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid with `rd_valid` |
| rd_valid | output | 1 | Read result present |
| cfg_open | output | 1 | Window is unlocked |
| flash_suspend | output | 1 | Flash-control bit 0 |
| flash_seg_en | output | 3 | Flash segment enables, control bits 3..1 |
| flash_host_wr | output | 1 | Host-to-flash write enable, control bit 4 |
| flash_pin_sel | output | 1 | Flash pin select, control bit 5 |
| flash_base | output | 16 | Flash controller base I/O address |

## Verification
The assertions assume that a read and a write strobe never occur in the same cycle. They also assume each strobe lasts one cycle per byte, so a key byte or an exit write is seen exactly once. The stimulus drives every access through one-cycle write and read tasks, one access at a time. Two instances on different bases share the bus, so each instance's address filter keeps the other's key and register traffic away from it.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    localparam logic [7:0] KEY_B0     = 8'h87;
    localparam logic [7:0] KEY_B1     = 8'h01;
    localparam logic [7:0] KEY_B2     = 8'h55;
    localparam logic [7:0] EXIT_IDX   = 8'h02;
    localparam logic [7:0] EXIT_VAL   = 8'h02;
    localparam logic [7:0] IDX_DEVSEL = 8'h07;
    localparam logic [7:0] IDX_ID_HI  = 8'h20;
    localparam logic [7:0] IDX_ID_LO  = 8'h21;
    localparam logic [7:0] IDX_FCTRL  = 8'h24;
    localparam logic [7:0] IDX_BASE_H = 8'h64;
    localparam logic [7:0] IDX_BASE_L = 8'h65;
    localparam logic [7:0] FLASH_DEV  = 8'h07;
    localparam logic [7:0] CLOSED_RD  = 8'hFF;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_GOT1,
        KS_GOT2,
        KS_GOT3
    } key_step_e;

    // Final key byte depends on the strapped base address.
    function automatic logic [7:0] final_key(input logic [15:0] base);
        return (base == 16'h002E) ? 8'h55 : 8'hAA;
    endfunction

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_port_pkg::*;
#(
    parameter logic [7:0] KEY_LAST = 8'h55
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       relock,
    output logic       open
);

    typedef struct packed {
        key_step_e step;
        logic      open;
    } key_state_t;

    key_state_t s_d, s_q;

    // A mismatch restarts; a mismatching 0x87 is itself a first byte.
    function automatic key_step_e restart(input logic [7:0] b);
        return (b == KEY_B0) ? KS_GOT1 : KS_IDLE;
    endfunction

    always_comb begin
        s_d = s_q;
        if (relock) begin
            s_d.open = 1'b0;
            s_d.step = KS_IDLE;
        end else if (key_wr && !s_q.open) begin
            unique case (s_q.step)
                KS_IDLE: s_d.step = restart(key_byte);
                KS_GOT1: s_d.step = (key_byte == KEY_B1) ? KS_GOT2 : restart(key_byte);
                KS_GOT2: s_d.step = (key_byte == KEY_B2) ? KS_GOT3 : restart(key_byte);
                KS_GOT3: begin
                    if (key_byte == KEY_LAST) begin
                        s_d.open = 1'b1;
                        s_d.step = KS_IDLE;
                    end else begin
                        s_d.step = restart(key_byte);
                    end
                end
                default: s_d.step = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.step <= KS_IDLE;
            s_q.open <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign open = s_q.open;

    // R1: opening is always caused by the final key byte
    assert_open_by_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.open) |-> $past(key_wr && key_byte == KEY_LAST));

    // R1: key bytes never reach the detector while it is open
    assert_no_key_when_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.open |-> (s_q.step == KS_IDLE));

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] CHIP_ID = 16'h8716
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        flash_suspend,
    output logic [2:0]  flash_seg_en,
    output logic        flash_host_wr,
    output logic        flash_pin_sel,
    output logic [15:0] flash_base
);

    typedef struct packed {
        logic [7:0] devsel;
        logic [7:0] fctrl;
        logic [7:0] base_hi;
        logic [7:0] base_lo;
    } reg_state_t;

    reg_state_t r_d, r_q;
    logic       flash_dev;

    assign flash_dev = (r_q.devsel == FLASH_DEV);

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (idx)
                IDX_DEVSEL: r_d.devsel = wdata;
                IDX_FCTRL:  r_d.fctrl  = wdata;
                IDX_BASE_H: if (flash_dev) r_d.base_hi = wdata;
                IDX_BASE_L: if (flash_dev) r_d.base_lo = wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (idx)
            IDX_ID_HI:  rdata = CHIP_ID[15:8];
            IDX_ID_LO:  rdata = CHIP_ID[7:0];
            IDX_DEVSEL: rdata = r_q.devsel;
            IDX_FCTRL:  rdata = r_q.fctrl;
            IDX_BASE_H: rdata = flash_dev ? r_q.base_hi : 8'h00;
            IDX_BASE_L: rdata = flash_dev ? r_q.base_lo : 8'h00;
            default:    rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign flash_suspend = r_q.fctrl[0];
    assign flash_seg_en  = r_q.fctrl[3:1];
    assign flash_host_wr = r_q.fctrl[4];
    assign flash_pin_sel = r_q.fctrl[5];
    assign flash_base    = {r_q.base_hi, r_q.base_lo};

    // R7: base pair moves only on a write to it with the flash device selected
    assert_base_guarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && r_q.devsel == FLASH_DEV && (idx == IDX_BASE_H || idx == IDX_BASE_L))
        |=> $stable(flash_base));

    // R8: control outputs move only on a write to the control index
    assert_fctrl_guarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && idx == IDX_FCTRL)
        |=> $stable({flash_pin_sel, flash_host_wr, flash_seg_en, flash_suspend}));

endmodule

// File: rtl/cfg_unlock_port.sv
module cfg_unlock_port
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] PORT_BASE = 16'h002E,
    parameter logic [15:0] CHIP_ID   = 16'h8716
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic        cfg_open,
    output logic        flash_suspend,
    output logic [2:0]  flash_seg_en,
    output logic        flash_host_wr,
    output logic        flash_pin_sel,
    output logic [15:0] flash_base
);

    localparam logic [15:0] DATA_ADDR = PORT_BASE + 16'd1;
    localparam logic [7:0]  KEY_LAST  = final_key(PORT_BASE);

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] rdata;
        logic       rvalid;
    } port_state_t;

    port_state_t p_d, p_q;

    logic       hit_idx, hit_dat, open;
    logic       key_wr, relock, reg_we;
    logic [7:0] reg_rdata;

    assign hit_idx = (bus_addr == PORT_BASE);
    assign hit_dat = (bus_addr == DATA_ADDR);
    assign key_wr  = wr_en && hit_idx && !open;
    assign relock  = wr_en && hit_dat && open
                     && p_q.index == EXIT_IDX && wr_data == EXIT_VAL;
    assign reg_we  = wr_en && hit_dat && open && !relock;

    cfg_key_fsm #(
        .KEY_LAST (KEY_LAST)
    ) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (wr_data),
        .relock   (relock),
        .open     (open)
    );

    cfg_regfile #(
        .CHIP_ID (CHIP_ID)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .we            (reg_we),
        .idx           (p_q.index),
        .wdata         (wr_data),
        .rdata         (reg_rdata),
        .flash_suspend (flash_suspend),
        .flash_seg_en  (flash_seg_en),
        .flash_host_wr (flash_host_wr),
        .flash_pin_sel (flash_pin_sel),
        .flash_base    (flash_base)
    );

    always_comb begin
        p_d        = p_q;
        p_d.rvalid = rd_en && (hit_idx || hit_dat);
        if (wr_en && hit_idx && open) begin
            p_d.index = wr_data;
        end
        if (rd_en && (hit_idx || hit_dat)) begin
            if (!open)        p_d.rdata = CLOSED_RD;
            else if (hit_dat) p_d.rdata = reg_rdata;
            else              p_d.rdata = p_q.index;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.index  <= '0;
            p_q.rdata  <= '0;
            p_q.rvalid <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rd_data  = p_q.rdata;
    assign rd_valid = p_q.rvalid;
    assign cfg_open = open;

    // R3: the exit write closes the window on the next cycle
    assert_exit_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && wr_en && hit_dat && p_q.index == EXIT_IDX && wr_data == EXIT_VAL)
        |=> !cfg_open);

    // R4: a read issued while closed returns the fill byte
    assert_closed_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (hit_idx || hit_dat) && !cfg_open) |=> (rd_valid && rd_data == CLOSED_RD));

    // R5: a read result follows its strobe by one cycle
    assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && (hit_idx || hit_dat)));

    // R4: closed-window data writes leave the control outputs alone
    assert_closed_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && wr_en && hit_dat)
        |=> $stable({flash_base, flash_pin_sel, flash_host_wr, flash_seg_en, flash_suspend}));

endmodule

// File: tb/sim_cfg_unlock_port.sv
`timescale 1ns/1ps
module sim_cfg_unlock_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_data = '0;

    logic [7:0]  rd_data0, rd_data1;
    logic        rd_valid0, rd_valid1, open0, open1;
    logic        susp0, susp1, hwr0, hwr1, pin0, pin1;
    logic [2:0]  seg0, seg1;
    logic [15:0] base0, base1;

    int tests = 0, fails = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #4 clk = ~clk;

    cfg_unlock_port #(.PORT_BASE(16'h002E)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data0), .rd_valid(rd_valid0), .cfg_open(open0),
        .flash_suspend(susp0), .flash_seg_en(seg0), .flash_host_wr(hwr0),
        .flash_pin_sel(pin0), .flash_base(base0));

    cfg_unlock_port #(.PORT_BASE(16'h004E)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data1), .rd_valid(rd_valid1), .cfg_open(open1),
        .flash_suspend(susp1), .flash_seg_en(seg1), .flash_host_wr(hwr1),
        .flash_pin_sel(pin1), .flash_base(base1));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp);
        req_q.push_back(req);
        bus_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic reg_wr(input logic [15:0] b, input logic [7:0] i, input logic [7:0] d);
        wr(b, i);
        wr(b + 16'd1, d);
    endtask

    task automatic reg_rd(input logic [15:0] b, input logic [7:0] i, input logic [7:0] exp,
                          input string req);
        wr(b, i);
        rd(b + 16'd1, exp, req);
    endtask

    task automatic key(input logic [15:0] b, input logic [7:0] last);
        wr(b, 8'h87); wr(b, 8'h01); wr(b, 8'h55); wr(b, last);
    endtask

    // Scoreboard monitor: pops one expected byte per returned read.
    always @(negedge clk) begin
        if (rd_valid0 || rd_valid1) begin
            if (exp_q.size() == 0) begin
                tests++; fails++;
                $display("FAIL R5: unexpected read result 0x%0h", rd_valid0 ? rd_data0 : rd_data1);
            end else begin
                check(req_q.pop_front(), 16'(rd_valid0 ? rd_data0 : rd_data1),
                      16'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(200000 * 8);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9 open", 16'(open0), 16'h0);
        check("R9 base", base0, 16'h0000);
        check("R9 ctrl", 16'({pin0, hwr0, seg0, susp0}), 16'h0);
        // R4: closed reads and writes
        rd(16'h002F, 8'hFF, "R4 closed data read");
        rd(16'h002E, 8'hFF, "R4 closed index read");
        wr(16'h002F, 8'h3F);
        check("R4 closed write", 16'({pin0, hwr0, seg0, susp0}), 16'h0);
        // R1: correct key opens u0 only
        key(16'h002E, 8'h55);
        check("R1 open 2E", 16'(open0), 16'h1);
        check("R1 other base shut", 16'(open1), 16'h0);
        // R6 identifier, R9 device select
        reg_rd(16'h002E, 8'h20, 8'h87, "R6 id hi");
        reg_rd(16'h002E, 8'h21, 8'h16, "R6 id lo");
        reg_wr(16'h002E, 8'h20, 8'h00);
        reg_rd(16'h002E, 8'h20, 8'h87, "R6 id read-only");
        reg_rd(16'h002E, 8'h07, 8'h00, "R9 devsel");
        reg_rd(16'h002E, 8'h24, 8'h00, "R4 ctrl untouched");
        rd(16'h002E, 8'h24, "R5 index readback");
        // R8 flash control 0x2B: suspend 1, seg 101, host wr 0, pin 1
        reg_wr(16'h002E, 8'h24, 8'h2B);
        check("R8 suspend", 16'(susp0), 16'h1);
        check("R8 seg", 16'(seg0), 16'h5);
        check("R8 host wr", 16'(hwr0), 16'h0);
        check("R8 pin", 16'(pin0), 16'h1);
        reg_wr(16'h002E, 8'h24, 8'h10);
        check("R8 host wr set", 16'({pin0, hwr0, seg0, susp0}), 16'h10);
        reg_rd(16'h002E, 8'h24, 8'h10, "R8 readback");
        // R7: base pair gated by device select
        reg_wr(16'h002E, 8'h64, 8'h12);
        reg_rd(16'h002E, 8'h64, 8'h00, "R7 hidden hi");
        check("R7 write dropped", base0, 16'h0000);
        reg_wr(16'h002E, 8'h07, 8'h07);
        reg_rd(16'h002E, 8'h07, 8'h07, "R7 devsel rw");
        reg_rd(16'h002E, 8'h64, 8'h00, "R7 base hi reset");
        reg_wr(16'h002E, 8'h64, 8'h0A);
        reg_wr(16'h002E, 8'h65, 8'h30);
        check("R10 base", base0, 16'h0A30);
        reg_rd(16'h002E, 8'h65, 8'h30, "R7 base lo");
        reg_wr(16'h002E, 8'h07, 8'h03);
        reg_rd(16'h002E, 8'h65, 8'h00, "R7 other device");
        check("R10 base kept", base0, 16'h0A30);
        // R3: exit
        reg_wr(16'h002E, 8'h02, 8'h05);
        check("R3 non-exit value", 16'(open0), 16'h1);
        wr(16'h002F, 8'h02);
        check("R3 closed", 16'(open0), 16'h0);
        rd(16'h002F, 8'hFF, "R4 read after exit");
        // R2: 0x87 restarts the key
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h01);
        key(16'h002E, 8'h55);
        check("R2 restart on 87", 16'(open0), 16'h1);
        reg_wr(16'h002E, 8'h02, 8'h02);
        wr(16'h002E, 8'h87); wr(16'h002E, 8'h01); wr(16'h002E, 8'h33);
        wr(16'h002E, 8'h55); wr(16'h002E, 8'h55);
        check("R2 bad byte", 16'(open0), 16'h0);
        key(16'h002E, 8'h55);
        check("R2 fresh key", 16'(open0), 16'h1);
        // R1: 0x4E base wants 0xAA
        key(16'h004E, 8'h55);
        check("R1 4E wrong last", 16'(open1), 16'h0);
        key(16'h004E, 8'hAA);
        check("R1 4E open", 16'(open1), 16'h1);
        reg_rd(16'h004E, 8'h21, 8'h16, "R6 id on 4E");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            tests++; fails++;
            $display("FAIL R5: actual %0d reads missing expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule